// File: doc/BRIEF.md
# PCI Target Parity Error Reporter

This block sits beside a 32-bit PCI target and watches the shared bus for parity faults. On every address phase, and on every write data phase that the local device accepts, it computes even parity over the AD and C/BE# lines. It then compares that result with PAR, which arrives one clock after the phase it covers. When the two disagree, it reports the fault on PERR# or SERR#, as the two enable bits of the command register allow. It also sets the sticky error bits of the status register.

Address parity is checked on every transaction on the bus, including those that are meant for other devices. A parity fault never changes how the cycle runs. The block has no claim, stop or abort output. The address decoder claims a faulty-address cycle as if the address were correct, and the initiator decides how to recover. Software clears the status bits by writing ones to the matching positions through a write-one-to-clear port.

Top module: `pci_par_monitor`

## Requirements
- R1: PAR is checked for even parity: PAR must equal the XOR of AD[31:0] and C/BE#[3:0] from the previous clock. When it does, the block reports no error and sets no status bit.
- R2: An address phase is a clock in which FRAME# is low, FRAME# was high on the clock before, and IRDY# is high. Its parity is checked whatever the value of tgt_sel_i.
- R3: A data phase is checked only when IRDY# and TRDY# are both low and tgt_sel_i and tgt_wr_i are both high. A parity mismatch on any other clock (for example a read, or a phase of another target) is ignored: no PERR#, no status change.
- R4: A data parity error drives perr_no low for exactly one clock, two clocks after the data phase. This happens only if perr_en_i is high on the clock that carries PAR. Back-to-back errored phases give back-to-back low clocks.
- R5: An address parity error drives serr_no low for exactly one clock, two clocks after the address phase. This happens only if perr_en_i and serr_en_i are both high on the clock that carries PAR.
- R6: Every detected parity error, address or data, sets sts_dpe_o (status bit 15), whatever the enables. The bit is set at the same edge at which PERR# or SERR# would be asserted.
- R7: sts_sse_o (status bit 14) is set whenever serr_no is pulsed, and at no other time.
- R8: Both status bits are sticky. A clock with sts_wr_i high clears each bit whose position in sts_wdata_i (bit 15 for DPE, bit 14 for SSE) is one. A zero in that position leaves the bit as it is, and a new error in the same clock wins over the clear.
- R9: While rst_ni is low, and after it rises, perr_no and serr_no are high (released) and both status bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PCI bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Multiplexed address/data lines |
| cbe_ni | input | 4 | Command / byte enables, active low |
| par_i | input | 1 | Even parity from the bus, one clock late |
| frame_ni | input | 1 | FRAME#, active low |
| irdy_ni | input | 1 | IRDY#, active low |
| trdy_ni | input | 1 | TRDY#, active low |
| tgt_sel_i | input | 1 | Decoder reports that this device is the selected target |
| tgt_wr_i | input | 1 | Current transaction is a write into this device |
| perr_en_i | input | 1 | Command register parity error response enable |
| serr_en_i | input | 1 | Command register system error enable |
| sts_wr_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | 2 (15:14) | Write-one-to-clear data for status bits 15 and 14 |
| perr_no | output | 1 | PERR#, active low, high when released |
| serr_no | output | 1 | SERR#, active low, high when released |
| sts_dpe_o | output | 1 | Detected parity error, status bit 15 |
| sts_sse_o | output | 1 | Signaled system error, status bit 14 |

## Verification
A phase sampled at edge k is judged against the PAR sampled at edge k+1. PERR#, SERR# and the status bits change at that same edge k+1, so they are valid on the bus at edge k+2. A status clear written in the cycle of edge j shows at edge j. The bench drives each bus cycle just after a falling edge. It then waits one rising edge and reads all outputs on the next falling edge. At that point it compares them with expectations formed from the phase it remembered from the previous cycle and the PAR and enables it has just driven. Directed sequences reuse the same step and add checks right after the step in which each result is due.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  localparam int unsigned STS_DPE_BIT = 15;
  localparam int unsigned STS_SSE_BIT = 14;

  // Phase captured at one edge, judged against PAR at the next.
  typedef struct packed {
    logic addr;
    logic data;
    logic calc;
  } phase_t;

endpackage

// File: rtl/par_lane_gen.sv
module par_lane_gen #(
  parameter int unsigned AD_W = 32,
  localparam int unsigned BE_W = AD_W / 8
) (
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_ni,
  output logic            par_o
);

  logic [BE_W-1:0] lane_par;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_par[g] = (^ad_i[g*8 +: 8]) ^ cbe_ni[g];
  end

  assign par_o = ^lane_par;

endmodule

// File: rtl/par_phase_track.sv
module par_phase_track
  import pci_par_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  localparam int unsigned BE_W = AD_W / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_ni,
  input  logic            frame_ni,
  input  logic            irdy_ni,
  input  logic            trdy_ni,
  input  logic            tgt_sel_i,
  input  logic            tgt_wr_i,
  output phase_t          phase_o
);

  logic frame_q;
  logic calc_par;
  logic addr_ph, data_ph;

  par_lane_gen #(.AD_W(AD_W)) u_gen (
    .ad_i   (ad_i),
    .cbe_ni (cbe_ni),
    .par_o  (calc_par)
  );

  // Address phase: FRAME# edge while bus idle; any target.
  assign addr_ph = !frame_ni && frame_q && irdy_ni;
  assign data_ph = !irdy_ni && !trdy_ni && tgt_sel_i && tgt_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b1;
      phase_o <= '0;
    end else begin
      frame_q      <= frame_ni;
      phase_o.addr <= addr_ph;
      phase_o.data <= data_ph;
      phase_o.calc <= calc_par;
    end
  end

  // Address and data phase cannot coincide: IRDY# high vs low.
  p_phase_excl_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_o.addr && phase_o.data));

endmodule

// File: rtl/par_err_eval.sv
module par_err_eval
  import pci_par_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_t phase_i,
  input  logic   par_i,
  input  logic   perr_en_i,
  input  logic   serr_en_i,
  output logic   det_o,
  output logic   sse_set_o,
  output logic   perr_no,
  output logic   serr_no
);

  logic mism, addr_err, data_err;
  logic perr_q, serr_q;

  assign mism     = phase_i.calc ^ par_i;
  assign addr_err = phase_i.addr & mism;
  assign data_err = phase_i.data & mism;

  assign det_o     = addr_err | data_err;
  assign sse_set_o = addr_err & perr_en_i & serr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      perr_q <= data_err & perr_en_i;
      serr_q <= sse_set_o;
    end
  end

  assign perr_no = ~perr_q;
  assign serr_no = ~serr_q;

  p_perr_needs_en_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(perr_en_i));

  p_serr_single_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |=> serr_no);

  p_serr_needs_en_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> ($past(perr_en_i) && $past(serr_en_i)));

endmodule

// File: rtl/par_status_regs.sv
module par_status_regs
  import pci_par_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         det_i,
  input  logic         sse_set_i,
  input  logic         sts_wr_i,
  input  logic [15:14] sts_wdata_i,
  output logic         sts_dpe_o,
  output logic         sts_sse_o
);

  logic clr_dpe, clr_sse;

  assign clr_dpe = sts_wr_i & sts_wdata_i[STS_DPE_BIT];
  assign clr_sse = sts_wr_i & sts_wdata_i[STS_SSE_BIT];

  // Set wins over a same-cycle clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_dpe_o <= 1'b0;
      sts_sse_o <= 1'b0;
    end else begin
      sts_dpe_o <= det_i     | (sts_dpe_o & ~clr_dpe);
      sts_sse_o <= sse_set_i | (sts_sse_o & ~clr_sse);
    end
  end

  p_dpe_sticky_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_dpe_o && !clr_dpe) |=> sts_dpe_o);

  p_sse_sticky_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_sse_o && !clr_sse) |=> sts_sse_o);

  p_sse_with_dpe_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_sse_o) |-> sts_dpe_o);

endmodule

// File: rtl/pci_par_monitor.sv
module pci_par_monitor
  import pci_par_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  localparam int unsigned BE_W = AD_W / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_ni,
  input  logic            par_i,
  input  logic            frame_ni,
  input  logic            irdy_ni,
  input  logic            trdy_ni,
  input  logic            tgt_sel_i,
  input  logic            tgt_wr_i,
  input  logic            perr_en_i,
  input  logic            serr_en_i,
  input  logic            sts_wr_i,
  input  logic [15:14]    sts_wdata_i,
  output logic            perr_no,
  output logic            serr_no,
  output logic            sts_dpe_o,
  output logic            sts_sse_o
);

  phase_t phase;
  logic   det, sse_set;

  par_phase_track #(.AD_W(AD_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ad_i      (ad_i),
    .cbe_ni    (cbe_ni),
    .frame_ni  (frame_ni),
    .irdy_ni   (irdy_ni),
    .trdy_ni   (trdy_ni),
    .tgt_sel_i (tgt_sel_i),
    .tgt_wr_i  (tgt_wr_i),
    .phase_o   (phase)
  );

  par_err_eval u_eval (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .par_i     (par_i),
    .perr_en_i (perr_en_i),
    .serr_en_i (serr_en_i),
    .det_o     (det),
    .sse_set_o (sse_set),
    .perr_no   (perr_no),
    .serr_no   (serr_no)
  );

  par_status_regs u_sts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .det_i       (det),
    .sse_set_i   (sse_set),
    .sts_wr_i    (sts_wr_i),
    .sts_wdata_i (sts_wdata_i),
    .sts_dpe_o   (sts_dpe_o),
    .sts_sse_o   (sts_sse_o)
  );

  p_serr_marks_sse_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> sts_sse_o);

  p_signal_marks_dpe_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!perr_no || !serr_no) |-> sts_dpe_o);

  p_perr_from_data_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(phase.data));

  p_serr_from_addr_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> $past(phase.addr));

endmodule

// File: tb/sim_pci_par_monitor.sv
module sim_pci_par_monitor;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_ni = '1;
  logic        par_i = 1'b0;
  logic        frame_ni = 1'b1, irdy_ni = 1'b1, trdy_ni = 1'b1;
  logic        tgt_sel_i = 1'b0, tgt_wr_i = 1'b0;
  logic        perr_en_i = 1'b0, serr_en_i = 1'b0;
  logic        sts_wr_i = 1'b0;
  logic [15:14] sts_wdata_i = '0;
  logic        perr_no, serr_no, sts_dpe_o, sts_sse_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // Bench model state (from the requirements)
  bit pf = 1, la = 0, ld = 0, lc = 0;
  bit exp_dpe = 0, exp_sse = 0, exp_perr_n = 1, exp_serr_n = 1;

  always #10 clk_i = ~clk_i;

  pci_par_monitor u0 (.*);

  function automatic bit even_par(logic [31:0] ad, logic [3:0] cbe);
    return ^{ad, cbe};
  endfunction

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %b exp %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // One bus cycle: drive, pass one rising edge, check at the falling edge.
  task automatic step(input bit fr, input bit ir, input bit tr, input bit sel,
                      input bit wr, input logic [31:0] ad, input logic [3:0] cbe,
                      input bit inj);
    bit aerr, derr;
    frame_ni = fr; irdy_ni = ir; trdy_ni = tr;
    tgt_sel_i = sel; tgt_wr_i = wr; ad_i = ad; cbe_ni = cbe;
    par_i = lc ^ inj;
    @(posedge clk_i);
    @(negedge clk_i);
    aerr = la & inj;
    derr = ld & inj;
    exp_perr_n = !(derr && perr_en_i);
    exp_serr_n = !(aerr && perr_en_i && serr_en_i);
    exp_dpe = aerr | derr | (exp_dpe & !(sts_wr_i && sts_wdata_i[15]));
    exp_sse = !exp_serr_n | (exp_sse & !(sts_wr_i && sts_wdata_i[14]));
    chk(perr_no, exp_perr_n, "R4", "perr_no");
    chk(serr_no, exp_serr_n, "R5", "serr_no");
    chk(sts_dpe_o, exp_dpe, "R6", "sts_dpe_o");
    chk(sts_sse_o, exp_sse, "R7", "sts_sse_o");
    la = !fr && pf && ir;
    ld = !ir && !tr && sel && wr;
    lc = even_par(ad, cbe);
    pf = fr;
  endtask

  task automatic idle(input bit inj);
    step(1, 1, 1, 0, 0, $urandom, 4'hF, inj);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk(perr_no, 1'b1, "R9", "perr_no in reset");
    chk(serr_no, 1'b1, "R9", "serr_no in reset");
    chk(sts_dpe_o, 1'b0, "R9", "dpe in reset");
    chk(sts_sse_o, 1'b0, "R9", "sse in reset");
    rst_ni = 1'b1;
    perr_en_i = 1; serr_en_i = 1;
    idle(0); idle(0);
    chk(sts_dpe_o, 1'b0, "R9", "dpe after reset");

    // R1: correct parity over random phases
    for (int i = 0; i < 6; i++) begin
      step(0, 1, 1, 1, 1, $urandom, 4'($urandom), 0);
      step(0, 0, 0, 1, 1, $urandom, 4'($urandom), 0);
      idle(0);
    end
    chk(sts_dpe_o, 1'b0, "R1", "dpe after clean parity");

    // R2: address error on a transaction for another target
    step(0, 1, 1, 0, 0, 32'hDEAD_BEEF, 4'h6, 0);
    step(0, 0, 1, 0, 0, $urandom, 4'h0, 1);
    chk(serr_no, 1'b0, "R2", "serr_no for foreign address error");
    chk(sts_sse_o, 1'b1, "R7", "sse set by serr");
    idle(0);
    chk(serr_no, 1'b1, "R5", "serr_no one clock only");

    // R8: clear both bits
    sts_wr_i = 1; sts_wdata_i = 2'b11;
    idle(0);
    sts_wr_i = 0; sts_wdata_i = 2'b00;
    chk(sts_dpe_o, 1'b0, "R8", "dpe cleared");
    chk(sts_sse_o, 1'b0, "R8", "sse cleared");

    // R3: read data phase with bad parity is ignored
    step(0, 1, 1, 1, 0, $urandom, 4'h6, 0);
    step(0, 0, 0, 1, 0, $urandom, 4'h0, 0);
    idle(1);
    chk(perr_no, 1'b1, "R3", "perr_no on read");
    chk(sts_dpe_o, 1'b0, "R3", "dpe on read");
    // R3: write phase with TRDY# high is ignored
    step(0, 1, 1, 1, 1, $urandom, 4'h7, 0);
    step(0, 0, 1, 1, 1, $urandom, 4'h0, 0);
    idle(1);
    chk(sts_dpe_o, 1'b0, "R3", "dpe on wait state");

    // R4: two back-to-back errored write data phases
    step(0, 1, 1, 1, 1, $urandom, 4'h7, 0);
    step(0, 0, 0, 1, 1, $urandom, 4'h0, 0);
    step(1, 0, 0, 1, 1, $urandom, 4'h0, 1);
    chk(perr_no, 1'b0, "R4", "perr_no first phase");
    idle(1);
    chk(perr_no, 1'b0, "R4", "perr_no second phase");
    idle(0);
    chk(perr_no, 1'b1, "R4", "perr_no released");

    // R8: error and clear in the same clock, set wins
    step(0, 1, 1, 0, 0, $urandom, 4'h6, 0);
    sts_wr_i = 1; sts_wdata_i = 2'b11;
    step(0, 0, 1, 0, 0, $urandom, 4'h0, 1);
    sts_wr_i = 0; sts_wdata_i = 2'b00;
    chk(sts_dpe_o, 1'b1, "R8", "dpe set wins");
    chk(sts_sse_o, 1'b1, "R8", "sse set wins");
    // R8: writing zeros leaves bits
    sts_wr_i = 1; sts_wdata_i = 2'b00;
    idle(0);
    sts_wr_i = 0;
    chk(sts_dpe_o, 1'b1, "R8", "dpe kept on zero write");
    sts_wr_i = 1; sts_wdata_i = 2'b11; idle(0); sts_wr_i = 0; sts_wdata_i = 2'b00;

    // R5/R6: SERR# enable off -> only DPE
    serr_en_i = 0;
    step(0, 1, 1, 1, 1, $urandom, 4'h7, 0);
    step(0, 0, 1, 1, 1, $urandom, 4'h0, 1);
    chk(serr_no, 1'b1, "R5", "serr_no with serr_en clear");
    chk(sts_dpe_o, 1'b1, "R6", "dpe without enables");
    chk(sts_sse_o, 1'b0, "R7", "sse stays clear");
    // R4/R6: parity response off -> no PERR#, DPE still set
    perr_en_i = 0; serr_en_i = 1;
    sts_wr_i = 1; sts_wdata_i = 2'b11; idle(0); sts_wr_i = 0; sts_wdata_i = 2'b00;
    step(0, 1, 1, 1, 1, $urandom, 4'h7, 0);
    step(0, 0, 0, 1, 1, $urandom, 4'h0, 0);
    idle(1);
    chk(perr_no, 1'b1, "R4", "perr_no with perr_en clear");
    chk(sts_dpe_o, 1'b1, "R6", "dpe with perr_en clear");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 64 == 0) begin
        perr_en_i = 1'($urandom);
        serr_en_i = 1'($urandom);
      end
      sts_wr_i = ($urandom % 16 == 0);
      sts_wdata_i = 2'($urandom);
      step(($urandom % 3) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), $urandom, 4'($urandom), ($urandom % 4) == 0);
    end
    sts_wr_i = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got running exp done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule